// File: doc/BRIEF.md
# Bidirectional 8-bit Timer Counter

This block is an eight-bit counter that steps once per timer tick. It suits a timer peripheral in which software picks where the tick comes from and how the count moves. A three-bit tick-source field can stop the counter. It can also feed the counter from a free-running prescaler on the system clock, or from the edges of an external pin.

A three-bit sequence field sets how the count moves. The counter can wrap freely upward, clear after reaching the value in compare register A, or run up and down between zero and a top value. A register port lets the CPU load the count in any cycle, and the count is always visible on an output. A sticky overflow flag is set by a mode-dependent event. The flag stays up until software clears it, and it also drives a level interrupt request.

Top module: `tick_counter8`

## Requirements
- R1: After reset, `count` is 0x00, `ovf_flag` is 0 and `irq` is 0.
- R2: With `tick_sel` = 0 there are no ticks, so `count` and `ovf_flag` hold their values unless the CPU writes the count.
- R3: A ten-bit prescaler counts system clocks from 0 starting at reset. Each `tick_sel` code gives a tick in the cycles listed here:
  - code 1: every cycle;
  - codes 2, 3, 4 and 5: the cycles where the low 3, 6, 8 or 10 prescaler bits are all ones, giving divide ratios of 8, 64, 256 and 1024.
- R4: `tick_sel` 6 counts falling edges of `ext_pin` and code 7 counts rising edges. The pin passes through a two-flop synchronizer and then an edge-detect flop, so the count changes on the third rising clock edge after the pin changes.
- R5: When `cnt_we` is high, `count` takes `cnt_wdata` at the next edge. Any clear, increment or decrement from a tick in that same cycle is dropped, and that tick cannot set the flag.
- R6: `seq_mode` 0 is normal mode, and the unused codes 3, 4, 6 and 7 behave the same way. Each tick adds one, and 0xFF wraps to 0x00. The tick that wraps sets the flag.
- R7: `seq_mode` 2 clears on compare. A tick that finds `count` equal to `cmp_a` loads 0x00; any other tick adds one. The flag is set only by a tick that finds `count` at 0xFF.
- R8: `seq_mode` 1 (top 0xFF) and `seq_mode` 5 (top `cmp_a`) count up and down between zero and the top value:
  - Counting up, a tick adds one while `count` is below the top. At or above the top, a tick turns the count around and subtracts one.
  - Counting down, a tick subtracts one.
  - A tick that brings the count to 0x00 sets the flag, and counting then resumes upward.
  - A down tick that finds 0x00 only turns the direction to up.
  - With top and count both at 0, the counter holds.
  - Leaving these modes resets the direction to up.
- R9: `ovf_flag` stays set until a cycle with `ovf_clr` high clears it. If a set event and `ovf_clr` fall in the same cycle, the set wins. `irq` always equals `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sel | input | 3 | Tick source: 0 stop, 1-5 prescaled clock, 6 falling pin edge, 7 rising pin edge |
| seq_mode | input | 3 | Counting sequence select |
| cmp_a | input | 8 | Compare register A (clear point or top value) |
| ext_pin | input | 1 | Asynchronous external count input |
| cnt_we | input | 1 | CPU write strobe for the count |
| cnt_wdata | input | 8 | CPU write data for the count |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| count | output | 8 | Current count value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets a CPU write that lands on a tick, most sharply when the count sits at 0xFF. A design that let the tick through would step past the written value or raise a false overflow. In clear-on-compare mode it runs compare values of 0xFF and values below the current count. A design that also flagged matches, or failed to flag the pass through 0xFF, shows up there. The up/down runs cover a top of zero, a top below the count after a write, and turns at both ends, where an off-by-one gives a wrong peak or a missing flag. A flag clear in the same cycle as a flag set checks that the event survives. Prescaled and pin-edge runs check the exact tick cycle, which catches a missing synchronizer stage or an inverted edge.

// File: rtl/tick_counter8.sv
`timescale 1ns/1ps
module tick_counter8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] tick_sel,
  input  logic [2:0] seq_mode,
  input  logic [7:0] cmp_a,
  input  logic       ext_pin,
  input  logic       cnt_we,
  input  logic [7:0] cnt_wdata,
  input  logic       ovf_clr,
  output logic [7:0] count,
  output logic       ovf_flag,
  output logic       irq
);
  localparam logic [2:0] SEQ_UPDN_FF = 3'd1;
  localparam logic [2:0] SEQ_CLR_CMP = 3'd2;
  localparam logic [2:0] SEQ_UPDN_A  = 3'd5;

  logic [9:0] pre;
  logic [2:0] pin_sh;
  logic       up, tick, hit, nxt_up, updn;
  logic [7:0] top, nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre    <= '0;
      pin_sh <= '0;
    end else begin
      pre    <= pre + 10'd1;
      pin_sh <= {pin_sh[1:0], ext_pin};
    end

  always_comb
    case (tick_sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre[2:0];
      3'd3:    tick = &pre[5:0];
      3'd4:    tick = &pre[7:0];
      3'd5:    tick = &pre;
      3'd6:    tick = !pin_sh[1] && pin_sh[2];
      3'd7:    tick = pin_sh[1] && !pin_sh[2];
      default: tick = 1'b0;
    endcase

  assign updn = (seq_mode == SEQ_UPDN_FF) || (seq_mode == SEQ_UPDN_A);
  assign top  = (seq_mode == SEQ_UPDN_A) ? cmp_a : 8'hFF;

  always_comb begin
    nxt    = count + 8'd1;
    nxt_up = up;
    hit    = 1'b0;
    if (updn) begin
      if (up && count < top) begin
        nxt = count + 8'd1;
      end else if (count == 8'd0) begin
        nxt    = count;
        nxt_up = 1'b1;
      end else begin
        nxt    = count - 8'd1;
        nxt_up = (count == 8'd1);
        hit    = (count == 8'd1);
      end
    end else begin
      hit = (count == 8'hFF);
      if (seq_mode == SEQ_CLR_CMP && count == cmp_a) nxt = 8'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count    <= '0;
      up       <= 1'b1;
      ovf_flag <= 1'b0;
    end else begin
      if (cnt_we)    count <= cnt_wdata;
      else if (tick) count <= nxt;
      if (!updn)                  up <= 1'b1;
      else if (tick && !cnt_we)   up <= nxt_up;
      if (tick && !cnt_we && hit) ovf_flag <= 1'b1;
      else if (ovf_clr)           ovf_flag <= 1'b0;
    end

  assign irq = ovf_flag;

  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sel == 3'd0 && !cnt_we) |=> (count == $past(count)));
  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count == $past(cnt_wdata)));
  a_r6_normal_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == 3'd0 && tick && !cnt_we) |=> (count == $past(count) + 8'd1));
  a_r7_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == SEQ_CLR_CMP && tick && !cnt_we && count == cmp_a) |=> (count == 8'd0));
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  a_r9_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(tick) && !$past(cnt_we)));
endmodule

// File: tb/test_tick_counter8.sv
`timescale 1ns/1ps
module test_tick_counter8;
  logic clk = 0, rst_n = 0;
  logic [2:0] sel = 0, md = 0;
  logic [7:0] cmp = 0, wd = 0;
  logic pin = 0, we = 0, clr = 0;
  logic [7:0] count;
  logic ovf_flag, irq;
  int checks = 0, errors = 0;
  string req = "R1";

  logic [7:0] m_cnt = 0;
  logic m_up = 1, m_ovf = 0;
  logic [9:0] m_pre = 0;
  logic [2:0] m_sh = 0;

  always #5 clk = ~clk;

  tick_counter8 i_tick_counter8 (.clk(clk), .rst_n(rst_n), .tick_sel(sel), .seq_mode(md),
    .cmp_a(cmp), .ext_pin(pin), .cnt_we(we), .cnt_wdata(wd), .ovf_clr(clr),
    .count(count), .ovf_flag(ovf_flag), .irq(irq));

  function automatic logic m_tick(input logic [2:0] s, input logic [9:0] p, input logic [2:0] sh);
    case (s)
      3'd1: return 1'b1;
      3'd2: return p[2:0] == 3'h7;
      3'd3: return p[5:0] == 6'h3F;
      3'd4: return p[7:0] == 8'hFF;
      3'd5: return p == 10'h3FF;
      3'd6: return sh[2] && !sh[1];
      3'd7: return !sh[2] && sh[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    logic t, pc, dn0;
    logic [7:0] tp, nc;
    logic nu, hit;
    t  = m_tick(sel, m_pre, m_sh);
    pc = (md == 3'd1) || (md == 3'd5);
    tp = (md == 3'd5) ? cmp : 8'hFF;
    nc = m_cnt; nu = m_up; hit = 0;
    if (pc) begin
      dn0 = (m_cnt == 0);
      if (m_up && m_cnt < tp) nc = m_cnt + 1;
      else if (dn0) nu = 1;
      else begin
        nc = m_cnt - 1;
        if (nc == 0) begin hit = 1; nu = 1; end else nu = 0;
      end
    end else begin
      hit = (m_cnt == 8'hFF);
      nc = (md == 3'd2 && m_cnt == cmp) ? 8'd0 : m_cnt + 8'd1;
      nu = 1;
    end
    @(posedge clk);
    if (we) m_cnt = wd; else if (t) m_cnt = nc;
    if (!pc) m_up = 1; else if (t && !we) m_up = nu;
    if (t && !we && hit) m_ovf = 1; else if (clr) m_ovf = 0;
    m_pre = m_pre + 1;
    m_sh = {m_sh[1:0], pin};
    @(negedge clk);
    check(count == m_cnt, "count", count, m_cnt);
    check(ovf_flag == m_ovf && irq == m_ovf, "flag", {ovf_flag, irq}, {m_ovf, m_ovf});
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cpu_write(input logic [7:0] v);
    we = 1; wd = v; step(); we = 0;
  endtask

  task automatic flag_clear();
    clr = 1; step(); clr = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    req = "R1";
    check(count == 0, "reset count", count, 0);
    check(ovf_flag == 0 && irq == 0, "reset flag", ovf_flag, 0);
    rst_n = 1;
    req = "R2"; sel = 0; run(20);
    req = "R6"; sel = 1; md = 0; run(300);
    req = "R9"; flag_clear(); run(5);
    req = "R5"; cpu_write(8'hFF); cpu_write(8'h40); run(3);
    cpu_write(8'hFF); req = "R9"; clr = 1; step(); clr = 0; run(2);
    flag_clear();
    req = "R2"; sel = 0; run(10); cpu_write(8'h77); run(10);
    req = "R6"; md = 3; sel = 1; run(20); md = 6; run(20);
    req = "R7"; md = 2; cmp = 8'd10; cpu_write(0); run(40);
    cmp = 8'd3; cpu_write(8'd20); run(300); flag_clear();
    cmp = 8'hFF; cpu_write(8'hF0); run(40);
    req = "R8"; md = 1; cpu_write(0); flag_clear(); run(600);
    md = 5; cmp = 8'd6; run(60); cpu_write(8'd50); run(80);
    cmp = 0; cpu_write(0); run(10); flag_clear();
    cmp = 8'd1; run(10); md = 0; run(4);
    req = "R3";
    for (int s = 2; s <= 5; s++) begin sel = 3'(s); md = 0; run(2200); end
    req = "R4";
    for (int s = 6; s <= 7; s++) begin
      sel = 3'(s);
      for (int k = 0; k < 200; k++) begin
        if ($urandom % 3 == 0) pin = ~pin;
        step();
      end
    end
    req = "R8";
    for (int i = 0; i < 6000; i++) begin
      if (i % 250 == 0) begin
        sel = 3'($urandom % 8); md = 3'($urandom % 8); cmp = 8'($urandom);
        if ($urandom % 2 == 0) sel = 3'd1;
        if ($urandom % 2 == 0) md = 3'd5;
      end
      we = ($urandom % 60 == 0); wd = 8'($urandom);
      clr = ($urandom % 25 == 0);
      if ($urandom % 4 == 0) pin = ~pin;
      step();
    end
    we = 0; clr = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule